// File: doc/BRIEF.md
# Character Row Pattern Generator

This block turns one character cell and one row index into the five dots that light up for that row during a display scan. When the upper four bits of the character code are zero, the dots come from a small writable pattern store that holds eight user glyphs of eight rows each. Bit 3 of the code is not used in that case, so each user glyph answers to two codes. Every other code is sent out on a read-only font port, and the block takes the dot row that comes back.

The block then adds the display effects. A cursor bar is ORed into the eighth row of the cell that holds the cursor. The cursor cell can blink, switching between its normal pattern and all dots lit; one divider sets the blink phase for every cell, so all blinking cells switch together. A two-bit pulse-width counter, stepped by a scan tick, gates the output to one of four brightness levels. The result is registered, so it appears one clock after the inputs that produced it.

Top module: `glyph_row_gen`

## Requirements
- R1: When code bits 7..4 are all zero, the row comes from the pattern store and code bit 3 has no effect (codes 00H and 08H give the same dots).
- R2: The pattern-store address is {code[2:0], row[2:0]}. Stored bits 4..0 are one row, with bit 4 the leftmost dot and a 1 meaning a lit dot.
- R3: When any of code bits 7..4 is set, the row is font_data_i. font_code_o and font_row_o always carry code_i and row_i unchanged.
- R4: When cursor enable and cursor-here are both 1 and the row index is 7, the output is the pattern ORed with 5'b11111. Rows 0..6 are not changed by the cursor.
- R5: When blink enable and cursor-here are both 1 and the blink phase is 1, every row of the cell reads 5'b11111. The phase is 0 after reset and toggles once every BLINK_HALF clocks.
- R6: A 2-bit dimming counter clears on reset and steps by one on each clock with scan_tick_i high. The enable is 1 only while the counter is below the duty: 4, 3, 2 and 1 for brightness codes 00, 01, 10 and 11 (100%, 75%, 50%, 25%).
- R7: When display-on is 0, row_o is 5'b00000 and row_en_o is 0. When the enable is 0, row_o is also 5'b00000.
- R8: Outputs are registered with one clock of latency and read 0 during reset.
- R9: A pattern write at a clock edge is seen by a lookup from the next clock on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pat_we_i | input | 1 | Pattern store write strobe |
| pat_waddr_i | input | 6 | Pattern store write address |
| pat_wdata_i | input | 5 | Pattern store write data |
| code_i | input | 8 | Character code of the cell |
| row_i | input | 3 | Row index inside the cell |
| cur_here_i | input | 1 | The cursor sits on this cell |
| disp_on_i | input | 1 | Display enable |
| cur_on_i | input | 1 | Cursor bar enable |
| blink_on_i | input | 1 | Cursor blink enable |
| bright_i | input | 2 | Brightness code |
| scan_tick_i | input | 1 | Steps the dimming counter |
| font_code_o | output | 8 | Code sent to the font port |
| font_row_o | output | 3 | Row sent to the font port |
| font_data_i | input | 5 | Dot row returned by the font port |
| row_o | output | 5 | Dot row, bit 4 leftmost |
| row_en_o | output | 1 | Row output enable |

## Verification
The bench checks the code 08H against 00H and the boundary codes 0FH and 10H. A design that decoded bit 3 would show a different glyph for 08H, and a design with a wrong nibble test would send 10H to the wrong source. It checks cursor-here with row 7 against rows 0..6, which catches a cursor bar put on the wrong row or drawn in every row. It runs past several blink phase changes, where an off-by-one divider would land the all-on half one cycle late. It steps each brightness code through full dimming periods, where a wrong boundary compare would give a duty one step off.

// File: rtl/glyph_pkg.sv
package glyph_pkg;
  localparam int unsigned DOT_W  = 5;
  localparam int unsigned CODE_W = 8;
  localparam int unsigned ROW_AW = 3;
  localparam int unsigned SEL_W  = 3;
  localparam int unsigned PAT_AW = SEL_W + ROW_AW;
  localparam int unsigned PAT_D  = 1 << PAT_AW;
  localparam int unsigned PWM_W  = 2;

  typedef logic [DOT_W-1:0] dots_t;

  // duty in scan ticks out of 4; code 00 is full on
  function automatic logic [PWM_W:0] duty_of(logic [PWM_W-1:0] br);
    return (PWM_W+1)'(1 << PWM_W) - {1'b0, br};
  endfunction
endpackage

// File: rtl/glyph_pat_ram.sv
module glyph_pat_ram
  import glyph_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [PAT_AW-1:0] waddr_i,
  input  dots_t             wdata_i,
  input  logic [PAT_AW-1:0] raddr_i,
  output dots_t             rdata_o
);
  dots_t mem_q [PAT_D];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];

  // R9
  pat_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> mem_q[$past(waddr_i)] == $past(wdata_i));
endmodule

// File: rtl/glyph_blink_div.sv
module glyph_blink_div #(
  parameter int unsigned BLINK_HALF = 25_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic phase_o
);
  localparam int unsigned CW = (BLINK_HALF > 1) ? $clog2(BLINK_HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(BLINK_HALF - 1);

  logic [CW-1:0] cnt_q;
  logic          phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else if (cnt_q == LAST) begin
      cnt_q   <= '0;
      phase_q <= ~phase_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign phase_o = phase_q;

  // R5
  phase_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != LAST) |=> $stable(phase_q));
endmodule

// File: rtl/glyph_dim_pwm.sv
module glyph_dim_pwm
  import glyph_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [PWM_W-1:0] bright_i,
  output logic             on_o
);
  logic [PWM_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + 1'b1;
  end

  assign on_o = {1'b0, cnt_q} < duty_of(bright_i);

  // R6
  pwm_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_q));
endmodule

// File: rtl/glyph_row_gen.sv
module glyph_row_gen
  import glyph_pkg::*;
#(
  parameter int unsigned BLINK_HALF = 25_000_000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pat_we_i,
  input  logic [PAT_AW-1:0] pat_waddr_i,
  input  logic [DOT_W-1:0]  pat_wdata_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [ROW_AW-1:0] row_i,
  input  logic              cur_here_i,
  input  logic              disp_on_i,
  input  logic              cur_on_i,
  input  logic              blink_on_i,
  input  logic [PWM_W-1:0]  bright_i,
  input  logic              scan_tick_i,
  output logic [CODE_W-1:0] font_code_o,
  output logic [ROW_AW-1:0] font_row_o,
  input  logic [DOT_W-1:0]  font_data_i,
  output logic [DOT_W-1:0]  row_o,
  output logic              row_en_o
);
  localparam logic [ROW_AW-1:0] CUR_ROW = ROW_AW'((1 << ROW_AW) - 1);
  localparam dots_t             ALL_ON  = '1;

  dots_t ram_dots;
  logic  phase;
  logic  pwm_on;
  logic  user_glyph;
  dots_t base_dots, fx_dots, nxt_dots;
  logic  nxt_en;

  assign font_code_o = code_i;
  assign font_row_o  = row_i;
  assign user_glyph  = (code_i[CODE_W-1:CODE_W-4] == '0);

  glyph_pat_ram u_ram (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (pat_we_i),
    .waddr_i (pat_waddr_i),
    .wdata_i (pat_wdata_i),
    .raddr_i ({code_i[SEL_W-1:0], row_i}),
    .rdata_o (ram_dots)
  );

  glyph_blink_div #(.BLINK_HALF(BLINK_HALF)) u_blink (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .phase_o (phase)
  );

  glyph_dim_pwm u_pwm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (scan_tick_i),
    .bright_i (bright_i),
    .on_o     (pwm_on)
  );

  always_comb begin
    base_dots = user_glyph ? ram_dots : font_data_i;
    fx_dots   = base_dots;
    if (cur_on_i && cur_here_i && (row_i == CUR_ROW)) fx_dots = fx_dots | ALL_ON;
    if (blink_on_i && cur_here_i && phase)            fx_dots = ALL_ON;
    nxt_en   = disp_on_i && pwm_on;
    nxt_dots = nxt_en ? fx_dots : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_o    <= '0;
      row_en_o <= 1'b0;
    end else begin
      row_o    <= nxt_dots;
      row_en_o <= nxt_en;
    end
  end

  // R7
  disp_off_blank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(disp_on_i) |-> (row_o == '0) && !row_en_o);
  // R7
  dots_need_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (row_o != '0) |-> row_en_o);
  // R4
  cursor_bar_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (disp_on_i && pwm_on && cur_on_i && cur_here_i && row_i == CUR_ROW)
      |=> row_o == ALL_ON);
endmodule

// File: tb/sim_glyph_row_gen.sv
`timescale 1ns/1ps
module sim_glyph_row_gen;
  localparam int HALF = 16;

  logic       clk_i = 0, rst_ni = 0;
  logic       pat_we_i = 0;
  logic [5:0] pat_waddr_i = 0;
  logic [4:0] pat_wdata_i = 0;
  logic [7:0] code_i = 0;
  logic [2:0] row_i = 0;
  logic       cur_here_i = 0, disp_on_i = 0, cur_on_i = 0, blink_on_i = 0;
  logic [1:0] bright_i = 0;
  logic       scan_tick_i = 0;
  logic [7:0] font_code_o;
  logic [2:0] font_row_o;
  logic [4:0] font_data_i;
  logic [4:0] row_o;
  logic       row_en_o;

  int checks = 0, fails = 0;
  logic [4:0] mem_m [64];
  int   pwm_m = 0, bcnt_m = 0;
  logic phase_m = 0;

  always #10 clk_i = ~clk_i;

  function automatic logic [4:0] font_f(logic [7:0] c, logic [2:0] r);
    return c[4:0] ^ {r, r[1:0]} ^ c[7:3];
  endfunction
  assign font_data_i = font_f(font_code_o, font_row_o);

  glyph_row_gen #(.BLINK_HALF(HALF)) u0 (.*);

  task automatic chk(string tag, logic [5:0] act, logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // drive at negedge, predict, clock, update model, check at next negedge
  task automatic step(string tag, bit do_chk);
    logic [4:0] d;
    logic en;
    d = (code_i[7:4] == 0) ? mem_m[{code_i[2:0], row_i}] : font_f(code_i, row_i);
    if (cur_on_i && cur_here_i && row_i == 3'd7) d = 5'h1f;
    if (blink_on_i && cur_here_i && phase_m) d = 5'h1f;
    en = disp_on_i && (pwm_m < 4 - int'(bright_i));
    if (!en) d = 0;
    @(posedge clk_i);
    if (scan_tick_i) pwm_m = (pwm_m + 1) % 4;
    if (bcnt_m == HALF - 1) begin bcnt_m = 0; phase_m = ~phase_m; end
    else bcnt_m++;
    if (pat_we_i) mem_m[pat_waddr_i] = pat_wdata_i;
    @(negedge clk_i);
    if (do_chk) chk(tag, {en, d}, {row_en_o, row_o});
  endtask

  task automatic idle_fx();
    cur_here_i = 0; cur_on_i = 0; blink_on_i = 0; scan_tick_i = 0;
    bright_i = 0; disp_on_i = 1; pat_we_i = 0;
  endtask

  initial begin
    #(20 * 190000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk_i);
    chk("R8 reset", {row_en_o, row_o}, 6'h0);
    rst_ni = 1;
    // R9 load every glyph row
    for (int a = 0; a < 64; a++) begin
      pat_we_i = 1; pat_waddr_i = 6'(a); pat_wdata_i = 5'($urandom);
      step("R9 load", 0);
    end
    pat_we_i = 0; idle_fx();
    // R1 bit 3 ignored, R2 addressing
    for (int r = 0; r < 8; r++) begin
      code_i = 8'h00; row_i = 3'(r); step("R1 code00", 1);
      code_i = 8'h08; step("R1 code08 alias", 1);
      code_i = 8'h0f; step("R2 code0f", 1);
      code_i = 8'h10; step("R3 code10 font", 1);
      chk("R3 font port", {font_code_o[5:0]}, 6'h10);
    end
    // R4 cursor bar only on row 7
    cur_on_i = 1; cur_here_i = 1; code_i = 8'h03;
    for (int r = 0; r < 8; r++) begin row_i = 3'(r); step("R4 cursor", 1); end
    cur_here_i = 0; row_i = 7; step("R4 cursor elsewhere", 1);
    // R5 blink over several phases
    idle_fx(); blink_on_i = 1; cur_here_i = 1; code_i = 8'h41;
    for (int i = 0; i < 4 * HALF; i++) begin row_i = 3'(i); step("R5 blink", 1); end
    // R6 each brightness code over full periods
    idle_fx(); scan_tick_i = 1; code_i = 8'hff;
    for (int b = 0; b < 4; b++) begin
      bright_i = 2'(b);
      for (int i = 0; i < 8; i++) step("R6 dim", 1);
    end
    // R7 display off
    idle_fx(); disp_on_i = 0; cur_on_i = 1; cur_here_i = 1; row_i = 7;
    step("R7 disp off", 1);
    // R9 write then read back
    idle_fx(); pat_we_i = 1; pat_waddr_i = 6'h2a; pat_wdata_i = 5'h15;
    code_i = 8'h85; row_i = 2; step("R9 write", 1);
    pat_we_i = 0; code_i = 8'h0d; row_i = 2; step("R9 readback", 1);
    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] x;
      x = $urandom;
      code_i = (x[0]) ? {4'h0, 4'(x[7:4])} : 8'(x[15:8]);
      row_i = 3'(x[18:16]); cur_here_i = x[19]; cur_on_i = x[20];
      blink_on_i = x[21]; bright_i = 2'(x[23:22]); scan_tick_i = x[24];
      disp_on_i = x[25] | x[26];
      pat_we_i = (x[29:27] == 0); pat_waddr_i = 6'($urandom); pat_wdata_i = 5'($urandom);
      if (!disp_on_i) step("R7 rand", 1);
      else if (code_i[7:4] == 0) step("R1 rand", 1);
      else step("R3 rand", 1);
    end
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule